// File: doc/BRIEF.md
# Chainable Serial Input Front End for a 10-Bit DAC

This block is the digital receive side of a serial-input 10-bit DAC. A host drives three wires: an active-low select, a serial clock that idles low, and a data line that the block samples on each rising serial-clock edge. All three wires are brought into the system clock domain through two-flop synchronisers. Edges are then found by comparing successive synchronised samples, so the system clock must run at least four times faster than the serial clock.

A frame is read MSB first. It carries ten code bits and then two trailing pad bits, which are ignored. A host may precede them with four dummy bits to make a 16-bit frame. The frame may arrive as one 16-bit burst or as two 8-bit bursts inside a single select-low window. When select rises, the ten code bits are taken from the window just above the last two bits received. They go into the parallel code register and a one-cycle load strobe is raised. If fewer than twelve rising edges arrived in the window, the code is kept and a one-cycle short-frame flag is raised instead.

The received bits also pass through a 16-deep shift path to a serial output. That output changes only on falling serial-clock edges while select is low. It always drives a level and never floats. Several devices can therefore be chained output-to-input, each taking 16 bits of a longer frame.

Top module: `sdac_front`

## Requirements
- R1: After reset, code_o is 0, dout_o is 0, load_o is 0 and short_o is 0.
- R2: When select rises after at least 12 rising serial-clock edges, code_o takes the 10 bits that were received 12th-last (as MSB) through 3rd-last (as LSB), and code_o changes at no other time.
- R3: The two last bits of a frame never affect code_o: frames with equal code bits and different pad bits give equal codes.
- R4: dout_o changes only in response to a falling serial-clock edge seen while select was low. It then takes the bit received 16 rising edges before the most recent rising edge, counting that edge as the first, so that a bit appears on dout_o at the falling edge after its 16th rising edge.
- R5: While select is high, serial-clock edges are ignored: dout_o holds its value, nothing is shifted and code_o does not change.
- R6: A select-low window with fewer than 12 rising edges leaves code_o unchanged, gives no load, and raises short_o for exactly one cycle.
- R7: A 16-bit frame of 4 dummy bits, 10 code bits (MSB first) and 2 pad bits loads exactly the 10 code bits.
- R8: A frame sent as two 8-bit bursts with a pause between them, inside one select-low window, loads the same code as one 16-bit burst.
- R9: With two devices chained (first dout_o into second din_i), one 32-bit frame loads the last 16-bit word into the first device and the first 16-bit word into the second.
- R10: When the last falling serial-clock edge and the rising edge of select arrive in the same system cycle, the dout_o update and the code load both take place.
- R11: load_o is high for exactly one cycle per accepted frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from host, idles low |
| sel_n_i | input | 1 | Active-low frame select |
| din_i | input | 1 | Serial data in, sampled on rising sclk |
| dout_o | output | 1 | Serial data out for chaining, updated on falling sclk |
| code_o | output | 10 | Parallel DAC code register |
| load_o | output | 1 | One-cycle strobe when code_o is loaded |
| short_o | output | 1 | One-cycle flag for a frame with too few edges |

## Verification
The block has two functions that can land in the same system cycle. One is the last falling-edge update of the serial output. The other is the load that fires when select rises. The bench provokes this by dropping the serial clock and raising select on the same system-clock edge at the end of a 16-bit frame. A behavioural model decides the outcome from the select state before the edge, and the bench checks that the falling edge still drives the first frame bit onto dout_o while the code loads in the same cycle.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    typedef struct packed {
        logic sclk;
        logic sel_n;
        logic din;
    } pins_t;

    typedef struct packed {
        logic rise;
        logic fall;
        logic close;
    } edges_t;

    localparam pins_t PINS_IDLE = '{sclk: 1'b0, sel_n: 1'b1, din: 1'b0};

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync
    import sdac_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t raw_i,
    output pins_t sync_o
);

    typedef struct packed {
        pins_t [STAGES-1:0] stage;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stage[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stage[i] = st_q.stage[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    st_q.stage[g] <= PINS_IDLE;
                end else begin
                    st_q.stage[g] <= st_d.stage[g];
                end
            end
        end
    endgenerate

    assign sync_o = st_q.stage[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
module sdac_edge
    import sdac_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  pins_t  pins_i,
    output edges_t ev_o,
    output logic   sel_o
);

    typedef struct packed {
        logic sclk;
        logic sel_n;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d       = prev_q;
        prev_d.sclk  = pins_i.sclk;
        prev_d.sel_n = pins_i.sel_n;

        ev_o.rise  = pins_i.sclk & ~prev_q.sclk & ~pins_i.sel_n;
        ev_o.fall  = ~pins_i.sclk & prev_q.sclk & ~prev_q.sel_n;
        ev_o.close = pins_i.sel_n & ~prev_q.sel_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '{sclk: 1'b0, sel_n: 1'b1};
        end else begin
            prev_q <= prev_d;
        end
    end

    assign sel_o = ~pins_i.sel_n;

endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  edges_t           ev_i,
    input  logic             din_i,
    output logic [DEPTH-1:0] word_o,
    output logic [CNT_W-1:0] count_o,
    output logic             dout_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0] shift;
        logic [CNT_W-1:0] count;
        logic             dout;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ev_i.rise) begin
            st_d.shift = {st_q.shift[DEPTH-2:0], din_i};
            if (st_q.count != CNT_MAX) begin
                st_d.count = st_q.count + 1'b1;
            end
        end
        if (ev_i.fall) begin
            st_d.dout = st_q.shift[DEPTH-1];
        end
        if (ev_i.close) begin
            st_d.count = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o  = st_q.shift;
    assign count_o = st_q.count;
    assign dout_o  = st_q.dout;

endmodule

// File: rtl/sdac_latch.sv
module sdac_latch #(
    parameter int CODE_W = 10,
    parameter int PAD_W  = 2,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              close_i,
    input  logic [DEPTH-1:0]  word_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CODE_W-1:0] code_o,
    output logic              load_o,
    output logic              short_o
);

    localparam logic [CNT_W-1:0] MIN_EDGES = CNT_W'(CODE_W + PAD_W);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              load;
        logic              short_f;
    } latch_st_t;

    latch_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.load    = 1'b0;
        st_d.short_f = 1'b0;
        if (close_i) begin
            if (count_i >= MIN_EDGES) begin
                st_d.code = word_i[PAD_W +: CODE_W];
                st_d.load = 1'b1;
            end else begin
                st_d.short_f = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o  = st_q.code;
    assign load_o  = st_q.load;
    assign short_o = st_q.short_f;

endmodule

// File: rtl/sdac_front.sv
module sdac_front
    import sdac_pkg::*;
#(
    parameter int CODE_W = 10,
    parameter int PAD_W  = 2,
    parameter int DEPTH  = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sel_n_i,
    input  logic              din_i,
    output logic              dout_o,
    output logic [CODE_W-1:0] code_o,
    output logic              load_o,
    output logic              short_o
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    pins_t            raw_s;
    pins_t            sync_s;
    edges_t           ev_s;
    logic             sel_s;
    logic [DEPTH-1:0] word_s;
    logic [CNT_W-1:0] count_s;

    assign raw_s = '{sclk: sclk_i, sel_n: sel_n_i, din: din_i};

    sdac_sync #(.STAGES(SYNC_N)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (raw_s),
        .sync_o (sync_s)
    );

    sdac_edge edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pins_i (sync_s),
        .ev_o   (ev_s),
        .sel_o  (sel_s)
    );

    sdac_shift #(.DEPTH(DEPTH), .CNT_W(CNT_W)) shift_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_i    (ev_s),
        .din_i   (sync_s.din),
        .word_o  (word_s),
        .count_o (count_s),
        .dout_o  (dout_o)
    );

    sdac_latch #(.CODE_W(CODE_W), .PAD_W(PAD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) latch_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .close_i (ev_s.close),
        .word_i  (word_s),
        .count_i (count_s),
        .code_o  (code_o),
        .load_o  (load_o),
        .short_o (short_o)
    );

endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
    parameter int CODE_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fall,
    input logic              close,
    input logic              dout,
    input logic [CODE_W-1:0] code,
    input logic              load,
    input logic              short_f
);

    assert_load_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !load);

    assert_short_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        short_f |=> !short_f);

    assert_short_no_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        short_f |-> !load);

    assert_code_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |-> $stable(code));

    assert_load_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> $past(close));

    assert_dout_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !fall |=> $stable(dout));

endmodule

bind sdac_front sdac_front_chk #(.CODE_W(CODE_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fall    (ev_s.fall),
    .close   (ev_s.close),
    .dout    (dout_o),
    .code    (code_o),
    .load    (load_o),
    .short_f (short_o)
);

// File: tb/sdac_front_tb.sv
`timescale 1ns/1ps
module sdac_front_tb_top;

    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sel_n = 1'b1;
    logic din = 1'b0;

    logic       dout_a, dout_b;
    logic [9:0] code_a, code_b;
    logic       load_a, load_b, short_a, short_b;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    sdac_front dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .din_i(din),
        .dout_o(dout_a), .code_o(code_a), .load_o(load_a), .short_o(short_a)
    );

    sdac_front dut_far_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n), .din_i(dout_a),
        .dout_o(dout_b), .code_o(code_b), .load_o(load_b), .short_o(short_b)
    );

    // behavioural reference model, one slot per device
    bit   m_bits [2][4096];
    int   m_n [2];
    int   m_cnt [2];
    logic m_a_sclk [2], m_a_sel [2], m_a_din [2];
    logic m_b_sclk [2], m_b_sel [2], m_b_din [2];
    logic m_p_sclk [2], m_p_sel [2];
    logic e_dout [2], e_load [2], e_short [2];
    logic [9:0] e_code [2];
    int   ld_cnt [2], sh_cnt [2];

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset(input int d);
        for (int i = 0; i < 4096; i++) m_bits[d][i] = 1'b0;
        m_n[d] = 16; m_cnt[d] = 0;
        m_a_sclk[d] = 0; m_a_sel[d] = 1; m_a_din[d] = 0;
        m_b_sclk[d] = 0; m_b_sel[d] = 1; m_b_din[d] = 0;
        m_p_sclk[d] = 0; m_p_sel[d] = 1;
        e_dout[d] = 0; e_load[d] = 0; e_short[d] = 0; e_code[d] = '0;
    endtask

    task automatic model_step(input int d, input logic i_sclk, input logic i_sel, input logic i_din);
        bit rise, fall, close;
        rise  = m_b_sclk[d] && !m_p_sclk[d] && !m_b_sel[d];
        fall  = !m_b_sclk[d] && m_p_sclk[d] && !m_p_sel[d];
        close = m_b_sel[d] && !m_p_sel[d];
        e_load[d] = 0; e_short[d] = 0;
        if (fall) e_dout[d] = m_bits[d][(m_n[d] - 16) % 4096];
        if (close) begin
            if (m_cnt[d] >= 12) begin
                for (int k = 0; k < 10; k++)
                    e_code[d][9-k] = m_bits[d][(m_n[d] - 12 + k) % 4096];
                e_load[d] = 1;
            end else begin
                e_short[d] = 1;
            end
            m_cnt[d] = 0;
        end
        if (rise) begin
            m_bits[d][m_n[d] % 4096] = m_b_din[d];
            m_n[d]++;
            m_cnt[d]++;
        end
        m_p_sclk[d] = m_b_sclk[d]; m_p_sel[d] = m_b_sel[d];
        m_b_sclk[d] = m_a_sclk[d]; m_b_sel[d] = m_a_sel[d]; m_b_din[d] = m_a_din[d];
        m_a_sclk[d] = i_sclk; m_a_sel[d] = i_sel; m_a_din[d] = i_din;
    endtask

    initial begin
        model_reset(0); model_reset(1);
        ld_cnt[0] = 0; ld_cnt[1] = 0; sh_cnt[0] = 0; sh_cnt[1] = 0;
    end

    always @(posedge clk) begin
        logic c_sclk, c_sel, c_din, c_dout_a;
        c_sclk = sclk; c_sel = sel_n; c_din = din; c_dout_a = dout_a;
        cyc++;
        if (!rst_n) begin
            model_reset(0); model_reset(1);
        end else begin
            model_step(0, c_sclk, c_sel, c_din);
            model_step(1, c_sclk, c_sel, c_dout_a);
            #2;
            check("R4 dout dev0", dout_a, e_dout[0]);
            check("R2 code dev0", code_a, e_code[0]);
            check("R11 load dev0", load_a, e_load[0]);
            check("R6 short dev0", short_a, e_short[0]);
            check("R4 dout dev1", dout_b, e_dout[1]);
            check("R2 code dev1", code_b, e_code[1]);
            check("R11 load dev1", load_b, e_load[1]);
            check("R6 short dev1", short_b, e_short[1]);
            if (load_a) ld_cnt[0]++;
            if (load_b) ld_cnt[1]++;
            if (short_a) sh_cnt[0]++;
            if (short_b) sh_cnt[1]++;
        end
    end

    always @(posedge clk) begin
        if (cyc == 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [31:0] w, input int nb, input int split_at, input bit tight);
        @(negedge clk);
        sel_n = 0;
        wait_cyc(HALF);
        for (int i = nb - 1; i >= 0; i--) begin
            din = w[i];
            wait_cyc(HALF);
            sclk = 1;
            wait_cyc(HALF);
            if (tight && i == 0) begin
                sclk = 0;
                sel_n = 1;
            end else begin
                sclk = 0;
            end
            if (split_at > 0 && i == split_at) wait_cyc(24);
        end
        if (!tight) begin
            wait_cyc(HALF);
            sel_n = 1;
        end
        wait_cyc(24);
    endtask

    initial begin
        int l0, s0;
        logic held;
        wait_cyc(5);
        check("R1 code", code_a, 0);
        check("R1 dout", dout_a, 0);
        check("R1 load", load_a, 0);
        check("R1 short", short_a, 0);
        rst_n = 1;
        wait_cyc(4);

        l0 = ld_cnt[0];
        send_frame({20'h0, 10'h2A5, 2'b11}, 12, 0, 0);
        check("R2 code 12-bit", code_a, 10'h2A5);
        check("R11 one load", ld_cnt[0] - l0, 1);

        l0 = ld_cnt[0];
        send_frame({20'h0, 10'h2A5, 2'b01}, 12, 0, 0);
        check("R3 pads ignored", code_a, 10'h2A5);
        check("R3 load seen", ld_cnt[0] - l0, 1);
        send_frame({20'h0, 10'h0F3, 2'b10}, 12, 0, 0);
        check("R3 new code", code_a, 10'h0F3);

        l0 = ld_cnt[0]; s0 = sh_cnt[0];
        send_frame({24'h0, 8'hFF}, 8, 0, 0);
        check("R6 code kept", code_a, 10'h0F3);
        check("R6 short flag", sh_cnt[0] - s0, 1);
        check("R6 no load", ld_cnt[0] - l0, 0);

        send_frame({16'h0, 4'hF, 10'h1C3, 2'b10}, 16, 0, 0);
        check("R7 dummy frame", code_a, 10'h1C3);

        l0 = ld_cnt[0];
        send_frame({16'h0, 4'b1000, 10'h2DB, 2'b01}, 16, 0, 1);
        check("R10 code", code_a, 10'h2DB);
        check("R10 load", ld_cnt[0] - l0, 1);
        check("R10 dout", dout_a, 1);

        held = dout_a; l0 = ld_cnt[0]; s0 = sh_cnt[0];
        for (int i = 0; i < 10; i++) begin
            din = ~held;
            wait_cyc(HALF); sclk = 1;
            wait_cyc(HALF); sclk = 0;
        end
        wait_cyc(12);
        check("R5 dout held", dout_a, held);
        check("R5 code held", code_a, 10'h2DB);
        check("R5 no events", (ld_cnt[0] - l0) + (sh_cnt[0] - s0), 0);

        send_frame({16'h0, 4'h0, 10'h155, 2'b00}, 16, 8, 0);
        check("R8 split frame", code_a, 10'h155);

        send_frame({4'h0, 10'h0F0, 2'b00, 4'hA, 10'h30C, 2'b11}, 32, 0, 0);
        check("R9 near device", code_a, 10'h30C);
        check("R9 far device", code_b, 10'h0F0);
        check("R4 near dout", dout_a, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule